// File: doc/BRIEF.md
# Asynchronous host bus bridge to dual-port RAM

This block connects an external host processor to one port of a shared dual-port RAM. The host has a parallel bus that is not multiplexed: a 12-bit word address, a 16-bit data path and two active-low strobes, chip select and write enable. The host bus runs with no timing relation to the block's clock. The block therefore passes both strobes through a synchronizer chain. On the synchronized falling edge of chip select it starts exactly one word-wide access to the RAM. Every access carries a full 16-bit word. There are no byte lanes, and address bit 0 picks the even or the odd word of a pair.

Completion is shown on an open-drain ready line. The line is pulled low while the access is in progress. It is then driven high for a number of clocks taken from a 4-bit setting, and after that it is released. A second open-drain line pulls low while the internal interrupt request is set. The data path is split into input, output and output-enable so that a pad cell can build the tri-state bus. Read data is put on the bus only while the host is actually reading. A 32-bit host transfer arrives as two separate 16-bit accesses, and each of them completes on its own.

Top module: `hbb_bridge`

## Requirements
- R1: The RAM address of an access equals the 12-bit host address sampled at the start of the access. Addresses 2k and 2k+1 reach two separate words.
- R2: A synchronized falling edge of `hb_cs_n` while `hb_we_n` is low produces exactly one single-cycle RAM write (`ram_en`=1, `ram_we`=1) of the host data at the host address.
- R3: A synchronized falling edge of `hb_cs_n` while `hb_we_n` is high produces one RAM read. The word read is shown on `hb_data_o` with `hb_data_oe`=1 from the first cycle in which ready is no longer pulled low.
- R4: `hb_data_oe` is 1 only when the read result is valid, `hb_cs_n` is low and `hb_we_n` is high. It is 0 right after `hb_cs_n` falls and goes to 0 at once when `hb_cs_n` rises.
- R5: Ready is pulled low (`hb_rdy_oe`=1, `hb_rdy_o`=0) from the cycle after the access starts until the RAM operation is complete. Any RAM operation happens while ready is pulled low.
- R6: After completion, ready is driven high (`hb_rdy_oe`=1, `hb_rdy_o`=1) for exactly N clocks, where N is `rdy_hold_cfg` in the range 1..15. Ready is then released (`hb_rdy_oe`=0).
- R7: When `rdy_hold_cfg` is 0, ready goes straight from pulled-low to released and is never driven high.
- R8: One low phase of `hb_cs_n` gives exactly one access, however long the phase lasts. The next access needs `hb_cs_n` to be seen high first.
- R9: Two accesses one after the other to an even address and then the odd address next to it (a split 32-bit transfer) each get their own RAM operation and their own ready sequence.
- R10: `hb_int_oe` (pad pulls low when 1) becomes 1 one clock after `irq_req` rises and 0 one clock after it falls.
- R11: While reset is asserted, and right after it, `hb_rdy_oe`, `hb_data_oe`, `hb_int_oe` and `ram_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_addr | input | 12 | Host word address |
| hb_data_i | input | 16 | Host data from the pad |
| hb_data_o | output | 16 | Read data to the pad |
| hb_data_oe | output | 1 | Pad output enable for the data path |
| hb_cs_n | input | 1 | Host chip select, active low, asynchronous |
| hb_we_n | input | 1 | Host write enable, active low, asynchronous |
| hb_rdy_o | output | 1 | Ready value while driven |
| hb_rdy_oe | output | 1 | Ready drive enable; 0 leaves the line to the pull-up |
| hb_int_oe | output | 1 | Interrupt pull-low enable (pad drives 0) |
| rdy_hold_cfg | input | 4 | Number of clocks ready is driven high |
| irq_req | input | 1 | Internal interrupt request |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM port write |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, valid one clock after the enable |

## Verification
Writes and reads are tried at even and odd addresses of one pair, at the top address, and as a back-to-back pair that stands for a split 32-bit transfer. This shows whether each address bit reaches the RAM and whether the two halves stay independent. The ready hold length is swept over 0, 1, 3 and 15, which separates an off-by-one in the high phase from a missing release or a wrong zero case. A chip select held low for a long time shows whether the block starts a second access. Checking the data enable at the fall and at the rise of chip select shows whether stale read data leaks onto the bus.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_ISSUE,
    ACC_RDLAT,
    ACC_WAITHI
  } acc_state_e;

  typedef enum logic [1:0] {
    RDY_REL,
    RDY_LOW,
    RDY_HIGH
  } rdy_state_e;
endpackage

// File: rtl/hbb_rst_sync.sv
module hbb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hbb_sync.sv
module hbb_sync #(
  parameter int         STAGES  = 2,
  parameter int         W       = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/hbb_access_fsm.sv
module hbb_access_fsm
  import hbb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s_n,
  input  logic              we_s_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              acc_start,
  output logic              acc_done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  acc_state_e        state_q, state_d;
  logic              cs_prev_q;
  logic              is_wr_q, is_wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;

  assign acc_start = (state_q == ACC_IDLE) && cs_prev_q && !cs_s_n;

  always_comb begin
    state_d  = state_q;
    is_wr_d  = is_wr_q;
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    rdata_d  = rdata_q;
    rvalid_d = rvalid_q;
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    acc_done = 1'b0;
    unique case (state_q)
      ACC_IDLE: begin
        if (acc_start) begin
          is_wr_d  = !we_s_n;
          addr_d   = host_addr;
          wdata_d  = host_wdata;
          rvalid_d = 1'b0;
          state_d  = ACC_ISSUE;
        end
      end
      ACC_ISSUE: begin
        ram_en = 1'b1;
        ram_we = is_wr_q;
        if (is_wr_q) begin
          acc_done = 1'b1;
          state_d  = ACC_WAITHI;
        end else begin
          state_d  = ACC_RDLAT;
        end
      end
      ACC_RDLAT: begin
        rdata_d  = ram_rdata;
        rvalid_d = 1'b1;
        acc_done = 1'b1;
        state_d  = ACC_WAITHI;
      end
      ACC_WAITHI: begin
        if (cs_s_n) begin
          rvalid_d = 1'b0;
          state_d  = ACC_IDLE;
        end
      end
      default: state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ACC_IDLE;
      cs_prev_q <= 1'b1;
      is_wr_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      cs_prev_q <= cs_s_n;
      is_wr_q   <= is_wr_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      rdata_q   <= rdata_d;
      rvalid_q  <= rvalid_d;
    end
  end

  assign ram_addr  = addr_q;
  assign ram_wdata = wdata_q;
  assign rd_data   = rdata_q;
  assign rd_valid  = rvalid_q;
endmodule

// File: rtl/hbb_ready_ctrl.sv
module hbb_ready_ctrl
  import hbb_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic              acc_done,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              rdy_o,
  output logic              rdy_oe
);
  rdy_state_e        state_q, state_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (acc_start) begin
      state_d = RDY_LOW;
    end else begin
      unique case (state_q)
        RDY_LOW: begin
          if (acc_done) begin
            if (hold_cfg != '0) begin
              state_d = RDY_HIGH;
              cnt_d   = hold_cfg;
            end else begin
              state_d = RDY_REL;
            end
          end
        end
        RDY_HIGH: begin
          if (cnt_q == HOLD_W'(1)) state_d = RDY_REL;
          else                     cnt_d   = cnt_q - 1'b1;
        end
        default: state_d = RDY_REL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RDY_REL;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rdy_oe = (state_q != RDY_REL);
  assign rdy_o  = (state_q == RDY_HIGH);
endmodule

// File: rtl/hbb_bridge.sv
module hbb_bridge #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 16,
  parameter int HOLD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [DATA_W-1:0] hb_data_i,
  output logic [DATA_W-1:0] hb_data_o,
  output logic              hb_data_oe,
  input  logic              hb_cs_n,
  input  logic              hb_we_n,
  output logic              hb_rdy_o,
  output logic              hb_rdy_oe,
  output logic              hb_int_oe,
  input  logic [HOLD_W-1:0] rdy_hold_cfg,
  input  logic              irq_req,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int STROBE_W = 2;

  logic                rst_n_sync;
  logic [STROBE_W-1:0] strobe_s;
  logic                acc_start, acc_done;
  logic [DATA_W-1:0]   rd_data;
  logic                rd_valid;
  logic                int_q;

  hbb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  hbb_sync #(.STAGES(SYNC_STAGES), .W(STROBE_W), .RST_VAL(2'b11)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .d_async ({hb_we_n, hb_cs_n}),
    .q_sync  (strobe_s)
  );

  hbb_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .cs_s_n     (strobe_s[0]),
    .we_s_n     (strobe_s[1]),
    .host_addr  (hb_addr),
    .host_wdata (hb_data_i),
    .ram_rdata  (ram_rdata),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .acc_start  (acc_start),
    .acc_done   (acc_done),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  hbb_ready_ctrl #(.HOLD_W(HOLD_W)) u_rdy (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .acc_start (acc_start),
    .acc_done  (acc_done),
    .hold_cfg  (rdy_hold_cfg),
    .rdy_o     (hb_rdy_o),
    .rdy_oe    (hb_rdy_oe)
  );

  // Data is driven only for a completed read while the host still reads;
  // the raw strobes gate it so release does not wait for the synchronizer.
  assign hb_data_o  = rd_data;
  assign hb_data_oe = rd_valid && !hb_cs_n && hb_we_n;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) int_q <= 1'b0;
    else             int_q <= irq_req;
  end
  assign hb_int_oe = int_q;
endmodule

// File: rtl/hbb_bridge_chk.sv
module hbb_bridge_chk #(
  parameter int HOLD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ram_en,
  input logic              ram_we,
  input logic              hb_rdy_o,
  input logic              hb_rdy_oe,
  input logic              hb_int_oe,
  input logic              irq_req,
  input logic [HOLD_W-1:0] rdy_hold_cfg
);
  // R2
  single_ram_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> !ram_en);

  // R2
  write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ram_en);

  // R5
  ram_under_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (hb_rdy_oe && !hb_rdy_o));

  // R7
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_hold_cfg == '0 && !(hb_rdy_oe && hb_rdy_o)) |=> !(hb_rdy_oe && hb_rdy_o));

  // R10
  int_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> hb_int_oe);

  // R10
  int_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |=> !hb_int_oe);
endmodule

bind hbb_bridge hbb_bridge_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .ram_en       (ram_en),
  .ram_we       (ram_we),
  .hb_rdy_o     (hb_rdy_o),
  .hb_rdy_oe    (hb_rdy_oe),
  .hb_int_oe    (hb_int_oe),
  .irq_req      (irq_req),
  .rdy_hold_cfg (rdy_hold_cfg)
);

// File: tb/hbb_bridge_tb_top.sv
module hbb_bridge_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;

  typedef struct {
    bit          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int          hold;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] hb_addr;
  logic [DW-1:0] hb_data_i;
  logic [DW-1:0] hb_data_o;
  logic hb_data_oe, hb_cs_n, hb_we_n, hb_rdy_o, hb_rdy_oe, hb_int_oe;
  logic [3:0] rdy_hold_cfg;
  logic irq_req;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata;

  logic [DW-1:0] ram_mem [1 << AW];
  logic [DW-1:0] exp_mem [1 << AW];
  exp_item_t     exp_q[$];
  int n_checks = 0;
  int n_fails  = 0;
  int ram_en_cnt = 0;

  always #5 clk = ~clk;

  hbb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .hb_addr(hb_addr), .hb_data_i(hb_data_i),
    .hb_data_o(hb_data_o), .hb_data_oe(hb_data_oe), .hb_cs_n(hb_cs_n),
    .hb_we_n(hb_we_n), .hb_rdy_o(hb_rdy_o), .hb_rdy_oe(hb_rdy_oe),
    .hb_int_oe(hb_int_oe), .rdy_hold_cfg(rdy_hold_cfg), .irq_req(irq_req),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // Single-cycle synchronous RAM model
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) ram_mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= ram_mem[ram_addr];
    end
  end

  always @(negedge clk) if (ram_en) ram_en_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  // Driver: one host access; pushes the expected result for the monitor
  task automatic host_access(input bit wr, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input int hold, input int gap);
    exp_item_t it;
    int en0;
    it.wr = wr; it.addr = a; it.hold = int'(rdy_hold_cfg);
    it.data = wr ? d : exp_mem[a];
    if (wr) exp_mem[a] = d;
    exp_q.push_back(it);
    @(negedge clk);
    hb_addr = a; hb_we_n = !wr; hb_data_i = wr ? d : 16'h0BAD;
    @(negedge clk);
    hb_cs_n = 1'b0;
    en0 = ram_en_cnt;
    #1;
    check(hb_data_oe == 1'b0, "R4 no drive at cs fall", int'(hb_data_oe), 0);
    repeat (hold) @(negedge clk);
    hb_cs_n = 1'b1;
    #1;
    check(hb_data_oe == 1'b0, "R4 release at cs rise", int'(hb_data_oe), 0);
    hb_we_n = 1'b1;
    repeat (gap) @(negedge clk);
    check(ram_en_cnt - en0 == 1, "R8 one RAM op per cs phase", ram_en_cnt - en0, 1);
  endtask

  // Monitor: pops expected items and compares the ready/data/RAM behaviour
  initial begin
    forever begin
      @(negedge clk);
      if (rdy_hold_cfg !== 4'hx && hb_rdy_oe && !hb_rdy_o) begin
        exp_item_t it;
        bit seen;
        logic [AW-1:0] seen_a;
        logic [DW-1:0] seen_d;
        bit seen_we;
        int hi;
        seen = 0; seen_a = '0; seen_d = '0; seen_we = 0; hi = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected ready low", 1, 0);
          it.wr = 0; it.addr = '0; it.data = '0; it.hold = 0;
        end else begin
          it = exp_q.pop_front();
        end
        while (hb_rdy_oe && !hb_rdy_o) begin
          if (ram_en) begin
            seen = 1; seen_a = ram_addr; seen_d = ram_wdata; seen_we = ram_we;
          end
          @(negedge clk);
        end
        check(seen, "R5 RAM op inside ready low", int'(seen), 1);
        check(seen_a == it.addr, "R1 RAM address", int'(seen_a), int'(it.addr));
        if (it.wr) begin
          check(seen_we && seen_d == it.data, "R2 RAM write data",
                int'(seen_d), int'(it.data));
        end else begin
          check(!seen_we, "R3 read issues no write", int'(seen_we), 0);
          check(hb_data_oe && hb_data_o == it.data, "R3 read data on bus",
                int'(hb_data_o), int'(it.data));
        end
        while (hb_rdy_oe && hb_rdy_o) begin
          hi++;
          @(negedge clk);
        end
        check(hi == it.hold, it.hold == 0 ? "R7 no high drive" : "R6 high length",
              hi, it.hold);
        check(!hb_rdy_oe, "R6 ready released", int'(hb_rdy_oe), 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 1, 0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin
      ram_mem[i] = DW'(i * 40503 + 7);
      exp_mem[i] = DW'(i * 40503 + 7);
    end
    ram_rdata = '0;
    rst_n = 1'b0; hb_cs_n = 1'b1; hb_we_n = 1'b1; hb_addr = '0;
    hb_data_i = '0; rdy_hold_cfg = 4'd3; irq_req = 1'b0;
    repeat (3) @(negedge clk);
    check(!hb_rdy_oe && !hb_data_oe && !hb_int_oe && !ram_en, "R11 in reset",
          {hb_rdy_oe, hb_data_oe, hb_int_oe, ram_en}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!hb_rdy_oe && !hb_data_oe && !hb_int_oe && !ram_en, "R11 after reset",
          {hb_rdy_oe, hb_data_oe, hb_int_oe, ram_en}, 0);

    // R2 / R3 / R6 basic write and read, N=3
    host_access(1, 12'h010, 16'h1234, 30, 4);
    host_access(0, 12'h010, 16'h0000, 30, 4);
    // R1 even/odd word pair distinct
    host_access(1, 12'h124, 16'hAAAA, 30, 4);
    host_access(1, 12'h125, 16'h5555, 30, 4);
    host_access(0, 12'h124, 16'h0000, 30, 4);
    host_access(0, 12'h125, 16'h0000, 30, 4);
    // R7 zero hold
    rdy_hold_cfg = 4'd0;
    host_access(1, 12'hFFF, 16'hBEEF, 30, 4);
    host_access(0, 12'hFFF, 16'h0000, 30, 4);
    host_access(0, 12'h3A1, 16'h0000, 30, 4);
    // R6 boundaries
    rdy_hold_cfg = 4'd1;
    host_access(0, 12'h001, 16'h0000, 30, 4);
    rdy_hold_cfg = 4'd15;
    host_access(1, 12'h800, 16'hC0DE, 30, 4);
    host_access(0, 12'h800, 16'h0000, 30, 4);
    // R8 long chip-select low phase
    rdy_hold_cfg = 4'd2;
    host_access(1, 12'h222, 16'h7E57, 80, 4);
    host_access(0, 12'h222, 16'h0000, 80, 4);
    // R9 split 32-bit transfer, minimal gap between halves
    host_access(1, 12'h456, 16'h0102, 25, 3);
    host_access(1, 12'h457, 16'h0304, 25, 3);
    host_access(0, 12'h456, 16'h0000, 25, 3);
    host_access(0, 12'h457, 16'h0000, 25, 3);

    // R10 interrupt pull-low enable
    @(negedge clk); irq_req = 1'b1;
    @(negedge clk);
    check(hb_int_oe, "R10 int asserted", int'(hb_int_oe), 1);
    irq_req = 1'b0;
    @(negedge clk);
    check(!hb_int_oe, "R10 int released", int'(hb_int_oe), 0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9 all accesses completed", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule